// File: doc/BRIEF.md
# Timer Channel Capture/Compare Status Flags

A 16-bit free-running timer channel with four general registers (GR0 to GR3) and a status register. Each general register works either as a capture register or as a compare register. In capture mode a rising edge on its capture input latches the counter value into it. In compare mode an equality between the counter and its value is reported. A channel-wide PWM mode turns GR3 into the cycle register, which restarts the counter, and GR2 into the duty register. Hardware events set status flags. Software clears a flag only by reading the status register while the flag is 1 and then writing 0 to that flag.

Each of the five flags (four general-register flags and one overflow flag) is controlled by its own small state machine. The states are FL_IDLE (flag 0), FL_SET (flag 1, not yet seen by software) and FL_ARMED (flag 1, seen by a status read).

The transitions are:
- FL_IDLE to FL_SET when a set event occurs.
- FL_SET to FL_ARMED on a status read.
- FL_ARMED to FL_IDLE on a status write of 0 to that bit when no set event occurs in the same cycle.
- FL_ARMED to FL_SET on any other status write.
- FL_SET stays in FL_SET on a status write.

The bus is a simple register port. Reads are combinational from the address. The read strobe only marks the cycle in which the status register is read.

The register map is:
- Address 0: control. Bits 3:0 select capture mode per GR (1 = capture), bit 4 is run, bit 5 is PWM.
- Address 1: status.
- Address 2: counter (writable).
- Addresses 4 to 7: GR0 to GR3.
- Address 3 reads 0.

Top module: `tmr_capcmp_status`

## Requirements
- R1: While the run bit (control bit 4) is 1 the counter increases by 1 each clock. While run is 0 it holds. A write to address 2 loads the counter.
- R2: The overflow flag, status bit 14, sets on the clock after the counter wraps from 0xFFFF to 0x0000.
- R3: Status bit 15 always reads 0 and bits 9:0 always read 0. Writes to these bits have no effect.
- R4: A flag clears only when a status write puts 0 in its bit after a status read while the flag was 1. A write of 0 without that read, or a write of 1, leaves the flag set. The flag bits are: GRn at status bit 10+n, overflow at bit 14.
- R5: In capture mode (control bit n = 1), a rising edge on cap_in[n] loads the current counter value into GRn on that clock and sets the GRn flag.
- R6: In compare mode, when the running counter equals GRn, the GRn flag sets and cmp_match[n] is high for exactly the following cycle.
- R7: In PWM mode (control bit 5), GR3 is a compare register whatever its mode bit says. When the running counter equals GR3 the counter becomes 0 on the next clock and the GR3 flag (bit 13) sets.
- R8: In PWM mode the GR2 flag (bit 12) never sets, although cmp_match[2] still pulses on a GR2 match.
- R9: If a set event and a valid clearing write hit the same flag in the same cycle, the flag stays 1.
- R10: After reset all flags, the counter, the control register and all general registers read 0, and cmp_match is 0.
- R11: The read-armed state is consumed by the next status write. After a read followed by a write that does not clear, a later write of 0 leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rd | input | 1 | Read strobe; marks a status read that arms set flags |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from bus_addr |
| cap_in | input | 4 | Capture inputs, one per general register, rising-edge active |
| cmp_match | output | 4 | One-cycle compare-match pulses, one per general register |

## Verification
Compare matching is swept over every general register with several distances between the counter start value and the register value. A per-cycle model of the counter and of each flag tells a match that fires one cycle early or late apart from a correct one. It also separates the flag from the match pulse. Capture is exercised on each input at different counter phases, which shows whether the latched value is the counter of the edge cycle or a neighbouring one. PWM runs with several cycle lengths show the restart point and the suppression of the GR2 flag. Dedicated handshake sequences distinguish:
- a blind write of 0,
- a write of 1,
- a consumed arm,
- a clear racing a capture event.

// File: rtl/tmr_capcmp_pkg.sv
package tmr_capcmp_pkg;

    typedef enum logic [1:0] {
        FL_IDLE  = 2'd0,
        FL_SET   = 2'd1,
        FL_ARMED = 2'd2
    } flag_st_e;

    localparam logic [2:0] ADR_CTRL = 3'd0;
    localparam logic [2:0] ADR_STAT = 3'd1;
    localparam logic [2:0] ADR_CNT  = 3'd2;

endpackage

// File: rtl/tmr_flag_fsm.sv
module tmr_flag_fsm
    import tmr_capcmp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_ev,
    input  logic st_rd,
    input  logic st_wr,
    input  logic wr_bit,
    output logic flag,
    output logic armed
);

    flag_st_e st_q;
    flag_st_e st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= FL_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            FL_IDLE: begin
                if (set_ev) st_d = FL_SET;
            end
            FL_SET: begin
                if (st_wr)      st_d = FL_SET;
                else if (st_rd) st_d = FL_ARMED;
            end
            FL_ARMED: begin
                if (st_wr) begin
                    if (!wr_bit && !set_ev) st_d = FL_IDLE;
                    else                    st_d = FL_SET;
                end
            end
            default: st_d = FL_IDLE;
        endcase
    end

    always_comb begin
        flag  = (st_q != FL_IDLE);
        armed = (st_q == FL_ARMED);
    end

endmodule

// File: rtl/tmr_gr_unit.sv
module tmr_gr_unit #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt,
    input  logic             tick,
    input  logic             cap_mode,
    input  logic             cap_edge,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] gr,
    output logic             set_ev,
    output logic             match_q
);

    logic cap_hit;
    logic cmp_hit;

    always_comb begin
        cap_hit = cap_mode & cap_edge;
        cmp_hit = !cap_mode && tick && (cnt == gr);
        set_ev  = cap_hit | cmp_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gr      <= '0;
            match_q <= 1'b0;
        end else begin
            if (cap_hit)    gr <= cnt;
            else if (wr_en) gr <= wdata;
            match_q <= cmp_hit;
        end
    end

endmodule

// File: rtl/tmr_capcmp_status.sv
module tmr_capcmp_status
    import tmr_capcmp_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int NUM_GR = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [2:0]        bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    input  logic [NUM_GR-1:0] cap_in,
    output logic [NUM_GR-1:0] cmp_match
);

    localparam int NUM_FLAG  = NUM_GR + 1;
    localparam int OVF_IDX   = NUM_GR;
    localparam int ST_LSB    = CNT_W - 1 - NUM_FLAG;
    localparam int IDX_DUTY  = NUM_GR - 2;
    localparam int IDX_CYCLE = NUM_GR - 1;
    localparam int CTRL_RUN  = NUM_GR;
    localparam int CTRL_PWM  = NUM_GR + 1;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [NUM_GR-1:0]             cap_mode_q;
    logic                          run_q;
    logic                          pwm_q;
    logic [NUM_GR-1:0]             cap_prev_q;
    logic [NUM_GR-1:0]             cap_edge;
    logic [CNT_W-1:0]              cnt_q;
    logic [NUM_GR-1:0][CNT_W-1:0]  gr_q;
    logic [NUM_GR-1:0]             gr_ev;
    logic [NUM_FLAG-1:0]           flag_set;
    logic [NUM_FLAG-1:0]           flag_q;
    logic [NUM_FLAG-1:0]           armed;
    logic                          wr_ctrl, wr_cnt, st_wr, st_rd;
    logic [NUM_GR-1:0]             wr_gr;
    logic [NUM_GR-1:0]             eff_cap;

    always_comb begin
        wr_ctrl  = bus_wr && (bus_addr == ADR_CTRL);
        wr_cnt   = bus_wr && (bus_addr == ADR_CNT);
        st_wr    = bus_wr && (bus_addr == ADR_STAT);
        st_rd    = bus_rd && (bus_addr == ADR_STAT);
        cap_edge = cap_in & ~cap_prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_mode_q <= '0;
            run_q      <= 1'b0;
            pwm_q      <= 1'b0;
            cap_prev_q <= '0;
        end else begin
            cap_prev_q <= cap_in;
            if (wr_ctrl) begin
                cap_mode_q <= bus_wdata[NUM_GR-1:0];
                run_q      <= bus_wdata[CTRL_RUN];
                pwm_q      <= bus_wdata[CTRL_PWM];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                  cnt_q <= '0;
        else if (wr_cnt)                             cnt_q <= bus_wdata;
        else if (run_q && pwm_q && cnt_q == gr_q[IDX_CYCLE]) cnt_q <= '0;
        else if (run_q)                              cnt_q <= cnt_q + 1'b1;
    end

    for (genvar g = 0; g < NUM_GR; g++) begin : g_gr
        localparam bit PWM_FORCED = (g == IDX_DUTY) || (g == IDX_CYCLE);
        always_comb begin
            eff_cap[g] = cap_mode_q[g] && !(pwm_q && PWM_FORCED);
            wr_gr[g]   = bus_wr && (bus_addr == 3'(NUM_GR + g));
            if (g == IDX_DUTY) flag_set[g] = gr_ev[g] && !pwm_q;
            else               flag_set[g] = gr_ev[g];
        end
        tmr_gr_unit #(.CNT_W(CNT_W)) u_gr (
            .clk      (clk),
            .rst_n    (rst_n),
            .cnt      (cnt_q),
            .tick     (run_q),
            .cap_mode (eff_cap[g]),
            .cap_edge (cap_edge[g]),
            .wr_en    (wr_gr[g]),
            .wdata    (bus_wdata),
            .gr       (gr_q[g]),
            .set_ev   (gr_ev[g]),
            .match_q  (cmp_match[g])
        );
    end

    always_comb flag_set[OVF_IDX] = run_q && (cnt_q == CNT_MAX);

    for (genvar f = 0; f < NUM_FLAG; f++) begin : g_flag
        tmr_flag_fsm u_fsm (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_ev (flag_set[f]),
            .st_rd  (st_rd),
            .st_wr  (st_wr),
            .wr_bit (bus_wdata[ST_LSB + f]),
            .flag   (flag_q[f]),
            .armed  (armed[f])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr[2]) begin
            bus_rdata = gr_q[bus_addr[1:0]];
        end else begin
            unique case (bus_addr[1:0])
                2'd0:    bus_rdata = {{(CNT_W-NUM_GR-2){1'b0}}, pwm_q, run_q, cap_mode_q};
                2'd1:    bus_rdata = {1'b0, flag_q, {ST_LSB{1'b0}}};
                2'd2:    bus_rdata = cnt_q;
                default: bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/tmr_capcmp_chk.sv
module tmr_capcmp_chk #(
    parameter int CNT_W    = 16,
    parameter int NUM_FLAG = 5
) (
    input logic                clk,
    input logic                rst_n,
    input logic                run,
    input logic                pwm,
    input logic                cnt_wr,
    input logic                st_wr,
    input logic                stat_sel,
    input logic                rdata_msb,
    input logic [CNT_W-1:0]    cnt,
    input logic [CNT_W-1:0]    gr_cycle,
    input logic [NUM_FLAG-1:0] flags,
    input logic [NUM_FLAG-1:0] armed
);

    localparam int OVF = NUM_FLAG - 1;
    localparam int DUTY = NUM_FLAG - 3;

    AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
        run && (cnt == '1) |=> flags[OVF]); // R2

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        stat_sel |-> !rdata_msb); // R3

    AST_PWM_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        pwm && run && !cnt_wr && (cnt == gr_cycle) |=> (cnt == '0)); // R7

    AST_PWM_DUTY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        pwm && !flags[DUTY] |=> !flags[DUTY]); // R8

    for (genvar f = 0; f < NUM_FLAG; f++) begin : g_f
        AST_BLIND_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
            flags[f] && !armed[f] && st_wr |=> flags[f]); // R4

        AST_CLEAR_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(flags[f]) |-> $past(armed[f] && st_wr)); // R4
    end

endmodule

bind tmr_capcmp_status tmr_capcmp_chk #(.CNT_W(CNT_W), .NUM_FLAG(NUM_FLAG)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run_q),
    .pwm       (pwm_q),
    .cnt_wr    (wr_cnt),
    .st_wr     (st_wr),
    .stat_sel  (bus_addr == 3'd1),
    .rdata_msb (bus_rdata[CNT_W-1]),
    .cnt       (cnt_q),
    .gr_cycle  (gr_q[IDX_CYCLE]),
    .flags     (flag_q),
    .armed     (armed)
);

// File: tb/sim_tmr_capcmp_status.sv
module sim_tmr_capcmp_status;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [15:0] bus_wdata = 16'd0;
    logic [15:0] bus_rdata;
    logic [3:0]  cap_in = 4'd0;
    logic [3:0]  cmp_match;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tmr_capcmp_status u0 (
        .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cap_in(cap_in), .cmp_match(cmp_match)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic bwr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic brd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic peek(input logic [2:0] a, output logic [15:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic clear_all();
        logic [15:0] t;
        brd(3'd1, t);
        bwr(3'd1, 16'h0000);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=%h exp=%h", 16'h0, 16'h1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] v, c, s, ecnt;
        logic exp_f, exp_p;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: reset state on every address, and R1: counter holds while stopped
        for (int a = 0; a < 8; a++) begin
            peek(3'(a), v);
            check("R10 reset read", v, 16'h0);
        end
        check("R10 cmp_match", {12'h0, cmp_match}, 16'h0);
        repeat (4) @(negedge clk);
        peek(3'd2, v);
        check("R1 counter holds when stopped", v, 16'h0);

        // R6 and R1: compare sweep over each register and distance
        for (int i = 0; i < 4; i++) begin
            for (int d = 1; d <= 5; d++) begin
                bwr(3'd0, 16'h0000);
                bwr(3'd2, 16'h1000);
                for (int j = 0; j < 4; j++) bwr(3'(4 + j), (j == i) ? 16'(16'h1000 + d) : 16'h8000);
                clear_all();
                bwr(3'd0, 16'h0010);
                ecnt = 16'h1000; exp_f = 1'b0; exp_p = 1'b0;
                for (int k = 0; k <= d + 2; k++) begin
                    peek(3'd2, c);
                    peek(3'd1, s);
                    check("R1 counter increments", c, ecnt);
                    check("R6 compare flag", {15'h0, s[10 + i]}, {15'h0, exp_f});
                    check("R6 compare pulse", {15'h0, cmp_match[i]}, {15'h0, exp_p});
                    exp_p = (ecnt == 16'(16'h1000 + d));
                    if (exp_p) exp_f = 1'b1;
                    ecnt = ecnt + 16'd1;
                    @(negedge clk);
                end
            end
        end

        // R2: overflow across the wrap
        bwr(3'd0, 16'h0000);
        for (int j = 0; j < 4; j++) bwr(3'(4 + j), 16'h8000);
        bwr(3'd2, 16'hFFFD);
        clear_all();
        bwr(3'd0, 16'h0010);
        ecnt = 16'hFFFD; exp_f = 1'b0;
        for (int k = 0; k < 6; k++) begin
            peek(3'd2, c);
            peek(3'd1, s);
            check("R1 counter wraps", c, ecnt);
            check("R2 overflow flag", {15'h0, s[14]}, {15'h0, exp_f});
            if (ecnt == 16'hFFFF) exp_f = 1'b1;
            ecnt = ecnt + 16'd1;
            @(negedge clk);
        end
        bwr(3'd0, 16'h0000);

        // R4 and R3: blind writes do not clear, reserved bits stay 0
        bwr(3'd1, 16'h0000);
        peek(3'd1, s);
        check("R4 blind write 0 keeps overflow", {15'h0, s[14]}, 16'h1);
        bwr(3'd1, 16'hFFFF);
        brd(3'd1, s);
        check("R3 bit15 reads 0", {15'h0, s[15]}, 16'h0);
        check("R3 low bits read 0", {6'h0, s[9:0]}, 16'h0);
        check("R4 write 1 keeps overflow", {15'h0, s[14]}, 16'h1);
        bwr(3'd1, 16'h0000);
        peek(3'd1, s);
        check("R4 read then write 0 clears", s, 16'h0);

        // R5: capture sweep at several counter phases
        bwr(3'd2, 16'h2000);
        bwr(3'd0, 16'h001F);
        for (int i = 0; i < 4; i++) begin
            for (int w = 0; w < 4; w++) begin
                repeat (w) @(negedge clk);
                peek(3'd2, c);
                cap_in[i] = 1'b1;
                @(negedge clk);
                cap_in[i] = 1'b0;
                peek(3'(4 + i), v);
                check("R5 captured value", v, c);
                peek(3'd1, s);
                check("R5 capture flag", {15'h0, s[10 + i]}, 16'h1);
                clear_all();
                peek(3'd1, s);
                check("R4 cleared after capture", s, 16'h0);
            end
        end

        // R9: set and clear in the same cycle, then R11: arm consumed
        cap_in[0] = 1'b1;
        @(negedge clk);
        cap_in[0] = 1'b0;
        brd(3'd1, s);
        @(negedge clk);
        bus_addr = 3'd1; bus_wdata = 16'h0000; bus_wr = 1'b1; cap_in[0] = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; cap_in[0] = 1'b0;
        peek(3'd1, s);
        check("R9 set wins over clear", {15'h0, s[10]}, 16'h1);
        bwr(3'd1, 16'h0000);
        peek(3'd1, s);
        check("R11 arm consumed by race write", {15'h0, s[10]}, 16'h1);
        brd(3'd1, s);
        bwr(3'd1, 16'h0400);
        bwr(3'd1, 16'h0000);
        peek(3'd1, s);
        check("R11 arm consumed by write 1", {15'h0, s[10]}, 16'h1);
        brd(3'd1, s);
        bwr(3'd1, 16'h0000);
        peek(3'd1, s);
        check("R4 final clear", {15'h0, s[10]}, 16'h0);

        // R7 and R8: PWM cycle sweep
        for (int p = 3; p <= 6; p++) begin
            bwr(3'd0, 16'h0000);
            bwr(3'd4, 16'h8000);
            bwr(3'd5, 16'h8000);
            bwr(3'd6, 16'h3002);
            bwr(3'd7, 16'(16'h3000 + p));
            bwr(3'd2, 16'h3000);
            clear_all();
            bwr(3'd0, 16'h003C);
            ecnt = 16'h3000; exp_f = 1'b0; exp_p = 1'b0;
            for (int k = 0; k < 2 * p + 8; k++) begin
                peek(3'd2, c);
                peek(3'd1, s);
                check("R7 PWM counter", c, ecnt);
                check("R7 cycle flag", {15'h0, s[13]}, {15'h0, exp_f});
                check("R8 duty flag stays 0", {15'h0, s[12]}, 16'h0);
                check("R8 duty pulse", {15'h0, cmp_match[2]}, {15'h0, exp_p});
                exp_p = (ecnt == 16'h3002);
                if (ecnt == 16'(16'h3000 + p)) begin
                    exp_f = 1'b1;
                    ecnt = 16'h0;
                end else begin
                    ecnt = ecnt + 16'd1;
                end
                @(negedge clk);
            end
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule